// File: doc/BRIEF.md
# Indexed Register Target on a Two-Wire Serial Bus

This block is a target-only I2C peripheral that holds a small set of control registers for a clock-distribution function: enables for two buffered outputs and two 8-bit divider selects. It also exposes a fixed identification byte. The bus lines are oversampled by the system clock. The block never stretches the clock; it only pulls SDA low to acknowledge or to send a zero.

A write transfer carries four parts in order. The first is the target address with the write bit. The second is a register offset that loads an internal pointer. The third is a count of the data bytes to follow. The data bytes come last and land at successive offsets. A read transfer loads the pointer the same way, with the offset as the only byte. The controller then issues a repeated start with the read bit. The target streams bytes from the pointer onward until the controller answers a byte with a not-acknowledge.

Top module: `i2cr_target`

## Requirements
- R1: The target acknowledges only the address byte 0xD4 (7-bit address 0x6A, write) or 0xD5 (read). Any other address byte is left unacknowledged, and the rest of that transfer changes no register.
- R2: After reset, both output enables are 1, divider A (offset 1) is 0x0F and divider B (offset 2) is 0x2E.
- R3: In a write, the byte after the address is the offset and the next byte is the count X. The following X data bytes are acknowledged and stored at offset, offset+1, and so on. The register outputs update after each byte.
- R4: A data byte beyond the count is not acknowledged and is not stored.
- R5: At offset 0, bit 5 drives the enable of output 3 and bit 4 drives the enable of output 4. The other bits of that register read as 0 and ignore writes.
- R6: Offsets 3, 4 and 5 read as 0. Writes to them are acknowledged and change nothing.
- R7: Offset 6 reads 0x01 (revision 0 in bits 7:4, vendor 1 in bits 3:0) and ignores writes.
- R8: After the offset is set and a repeated start with 0xD5 is sent, the target returns bytes from successive offsets. It stops driving SDA once the controller not-acknowledges a byte.
- R9: A stop or start condition arriving partway through a byte abandons that byte without storing it. A start then begins a fresh address phase.
- R10: A pulse of one or two system clocks on SCL or SDA is rejected by the input filter and does not disturb a transfer.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low (open-drain enable) |
| out3_en | output | 1 | Enable for buffered output 3 |
| out4_en | output | 1 | Enable for buffered output 4 |
| div_a | output | 8 | Divider select A |
| div_b | output | 8 | Divider select B |

## Verification
The hardest cases to reach from the ports are the conditions that cut a byte short. The first is a stop or repeated start after only a few bits of a data byte, once the address, offset and count have all been accepted. The second is a narrow spike on SCL or SDA that would count as an extra clock or a false start if the filter let it through. The bench reaches both with a controller model that emits partial bytes and drops two-cycle spikes into bit cells. It then confirms at the register outputs that nothing was stored, and confirms that a full transfer right after still succeeds.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
  localparam logic [6:0] TGT_ADDR   = 7'h6A;
  localparam logic [7:0] OFS_CTRL   = 8'd0;
  localparam logic [7:0] OFS_DIVA   = 8'd1;
  localparam logic [7:0] OFS_DIVB   = 8'd2;
  localparam logic [7:0] OFS_IDENT  = 8'd6;
  localparam int         EN3_BIT    = 5;
  localparam int         EN4_BIT    = 4;
  localparam logic [7:0] DIVA_RST   = 8'h0F;
  localparam logic [7:0] DIVB_RST   = 8'h2E;
  localparam logic [7:0] IDENT_BYTE = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_OFFS, PH_CNT, PH_DATA
  } byte_phase_t;
endpackage

// File: rtl/i2cr_filt.sv
`timescale 1ns/1ps
module i2cr_filt #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;
  localparam logic [FILT_LEN-1:0] ALL1 = {FILT_LEN{1'b1}};
  localparam logic [FILT_LEN-1:0] ALL0 = {FILT_LEN{1'b0}};

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= {SYNC_LEN{1'b1}};
      hist_q  <= ALL1;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], raw_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (hist_q == ALL1)      clean_o <= 1'b1;
      else if (hist_q == ALL0) clean_o <= 1'b0;
    end
  end

  // output only moves after a full run of agreeing samples
  AST_FILTER_RUN: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean_o) |-> ($past(hist_q) == {FILT_LEN{clean_o}})); // R10
endmodule

// File: rtl/i2cr_regs.sv
`timescale 1ns/1ps
module i2cr_regs
  import i2cr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          en3,
  output logic          en4,
  output logic [DW-1:0] div_a,
  output logic [DW-1:0] div_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en3   <= 1'b1;
      en4   <= 1'b1;
      div_a <= DIVA_RST;
      div_b <= DIVB_RST;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_CTRL: begin
          en3 <= wr_data[EN3_BIT];
          en4 <= wr_data[EN4_BIT];
        end
        OFS_DIVA: div_a <= wr_data;
        OFS_DIVB: div_b <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CTRL: begin
        rd_data[EN3_BIT] = en3;
        rd_data[EN4_BIT] = en4;
      end
      OFS_DIVA:  rd_data = div_a;
      OFS_DIVB:  rd_data = div_b;
      OFS_IDENT: rd_data = IDENT_BYTE;
      default:   rd_data = '0;
    endcase
  end

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en3 && en4 && div_a == DIVA_RST && div_b == DIVB_RST)); // R2

  AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > OFS_DIVB) |=>
      ($stable(div_a) && $stable(div_b) && $stable(en3) && $stable(en4))); // R6
endmodule

// File: rtl/i2cr_target.sv
`timescale 1ns/1ps
module i2cr_target
  import i2cr_pkg::*;
#(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int AW       = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_low,
  output logic       out3_en,
  output logic       out4_en,
  output logic [7:0] div_a,
  output logic [7:0] div_b
);
  localparam int NLINES = 2;
  localparam int BITW   = 4;

  logic [NLINES-1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cr_filt #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst(rst), .raw_i(raw_lines[g]), .clean_o(clean_lines[g]));
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

  link_state_t      st;
  byte_phase_t      ph;
  logic [BITW-1:0]  nbits;
  logic [7:0]       shreg;
  logic [AW-1:0]    ptr;
  logic [7:0]       left;
  logic             go_tx;
  logic             ctl_ack;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  i2cr_regs #(.AW(AW), .DW(8)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data),
    .en3(out3_en), .en4(out4_en), .div_a(div_a), .div_b(div_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      ph           <= PH_ADDR;
      nbits        <= '0;
      shreg        <= '0;
      ptr          <= '0;
      left         <= '0;
      go_tx        <= 1'b0;
      ctl_ack      <= 1'b0;
      sda_pull_low <= 1'b0;
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        st           <= ST_RX;
        ph           <= PH_ADDR;
        nbits        <= '0;
        sda_pull_low <= 1'b0;
      end else if (bus_stop) begin
        st           <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              nbits <= nbits + 1'b1;
            end else if (scl_fall && nbits == BITW'(8)) begin
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] == TGT_ADDR) begin
                    sda_pull_low <= 1'b1;
                    st           <= ST_RXACK;
                    go_tx        <= shreg[0];
                    ph           <= PH_OFFS;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                PH_OFFS: begin
                  ptr          <= shreg;
                  go_tx        <= 1'b0;
                  sda_pull_low <= 1'b1;
                  st           <= ST_RXACK;
                  ph           <= PH_CNT;
                end
                PH_CNT: begin
                  left         <= shreg;
                  go_tx        <= 1'b0;
                  sda_pull_low <= 1'b1;
                  st           <= ST_RXACK;
                  ph           <= PH_DATA;
                end
                default: begin
                  if (left != 8'd0) begin
                    wr_en        <= 1'b1;
                    wr_addr      <= ptr;
                    wr_data      <= shreg;
                    ptr          <= ptr + 1'b1;
                    left         <= left - 1'b1;
                    go_tx        <= 1'b0;
                    sda_pull_low <= 1'b1;
                    st           <= ST_RXACK;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              nbits <= '0;
              if (go_tx) begin
                st           <= ST_TX;
                shreg        <= rd_data;
                sda_pull_low <= ~rd_data[7];
                ptr          <= ptr + 1'b1;
              end else begin
                st           <= ST_RX;
                sda_pull_low <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (nbits == BITW'(7)) begin
                st           <= ST_TXACK;
                sda_pull_low <= 1'b0;
              end else begin
                nbits        <= nbits + 1'b1;
                shreg        <= {shreg[6:0], 1'b0};
                sda_pull_low <= ~shreg[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              ctl_ack <= ~sda_f;
            end else if (scl_fall) begin
              nbits <= '0;
              if (ctl_ack) begin
                st           <= ST_TX;
                shreg        <= rd_data;
                sda_pull_low <= ~rd_data[7];
                ptr          <= ptr + 1'b1;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_low) |-> !$past(scl_f)); // R11

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_WAIT) |-> !sda_pull_low); // R8

  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (st == ST_RXACK && sda_pull_low)); // R3
endmodule

// File: tb/i2cr_target_tb.sv
`timescale 1ns/1ps
module i2cr_target_tb_top;
  localparam int  Q   = 100;      // quarter bit time in ns (20 clocks)
  localparam real TCK = 5.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_low, out3_en, out4_en;
  logic [7:0] div_a, div_b;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull_low;

  always #(TCK/2) clk = ~clk;

  i2cr_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_low(sda_pull_low), .out3_en(out3_en), .out4_en(out4_en),
    .div_a(div_a), .div_b(div_b));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int drive_viol = 0;
  logic prev_pull = 1'b0;
  logic prev_scl  = 1'b1;
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];

  // R11 monitor: data drive must not move while the bus clock is high
  always @(negedge clk) begin
    if (!rst && prev_scl && scl_m && (sda_pull_low != prev_pull))
      drive_viol++;
    prev_pull = sda_pull_low;
    prev_scl  = scl_m;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bstop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; #Q;
    if (glitch) begin
      scl_m = 1'b1; #10; scl_m = 1'b0; #(Q-10);
    end
    scl_m = 1'b1; #Q;
    if (glitch && b) begin
      sda_m = 1'b0; #10; sda_m = 1'b1; #(Q-10);
    end else begin
      #Q;
    end
    scl_m = 1'b0; #Q;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    recv_bit(nack);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(last, 1'b0);
  endtask

  task automatic do_write(input string tag, input logic [7:0] ofs, input int cnt, input int nsend, input bit glitch);
    logic nk;
    bstart();
    send_byte(8'hD4, glitch, nk); chk({tag, " R1 addr ack"}, nk, 1'b0);
    send_byte(ofs, glitch, nk);   chk({tag, " R3 offset ack"}, nk, 1'b0);
    send_byte(8'(cnt), glitch, nk); chk({tag, " R3 count ack"}, nk, 1'b0);
    for (int i = 0; i < nsend; i++) begin
      send_byte(wbuf[i], glitch, nk);
      if (i < cnt) chk({tag, " R3 data ack"}, nk, 1'b0);
      else         chk({tag, " R4 excess nack"}, nk, 1'b1);
    end
    bstop();
  endtask

  task automatic do_read(input string tag, input logic [7:0] ofs, input int n);
    logic nk;
    bstart();
    send_byte(8'hD4, 1'b0, nk); chk({tag, " R8 addr ack"}, nk, 1'b0);
    send_byte(ofs, 1'b0, nk);   chk({tag, " R8 offset ack"}, nk, 1'b0);
    bstart();
    send_byte(8'hD5, 1'b0, nk); chk({tag, " R1 read addr ack"}, nk, 1'b0);
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n-1));
    #Q;
    chk({tag, " R8 released after nack"}, sda_pull_low, 1'b0);
    bstop();
  endtask

  task automatic t_reset();
    chk("R2 out3_en", out3_en, 1'b1);
    chk("R2 out4_en", out4_en, 1'b1);
    chk("R2 div_a", div_a, 8'h0F);
    chk("R2 div_b", div_b, 8'h2E);
    chk("R2 sda idle", sda_pull_low, 1'b0);
  endtask

  task automatic t_write();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C;
    do_write("wr", 8'd1, 2, 2, 1'b0);
    chk("R3 div_a", div_a, 8'hA5);
    chk("R3 div_b", div_b, 8'h3C);
  endtask

  task automatic t_overrun();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write("ovr", 8'd1, 1, 2, 1'b0);
    chk("R4 div_a stored", div_a, 8'h11);
    chk("R4 div_b untouched", div_b, 8'h3C);
  endtask

  task automatic t_ctrl();
    wbuf[0] = 8'h00;
    do_write("ctl0", 8'd0, 1, 1, 1'b0);
    chk("R5 out3 off", out3_en, 1'b0);
    chk("R5 out4 off", out4_en, 1'b0);
    wbuf[0] = 8'h20;
    do_write("ctl1", 8'd0, 1, 1, 1'b0);
    chk("R5 out3 bit5", out3_en, 1'b1);
    chk("R5 out4 bit4", out4_en, 1'b0);
    wbuf[0] = 8'hFF;
    do_write("ctl2", 8'd0, 1, 1, 1'b0);
    do_read("ctlrd", 8'd0, 1);
    chk("R5 reserved bits zero", rbuf[0], 8'h30);
  endtask

  task automatic t_reserved();
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hFF;
    do_write("rsv", 8'd3, 4, 4, 1'b0);
    do_read("rsvrd", 8'd2, 5);
    chk("R6 div_b kept", rbuf[0], 8'h3C);
    chk("R6 ofs3 zero", rbuf[1], 8'h00);
    chk("R6 ofs4 zero", rbuf[2], 8'h00);
    chk("R6 ofs5 zero", rbuf[3], 8'h00);
    chk("R7 ident", rbuf[4], 8'h01);
  endtask

  task automatic t_read();
    do_read("seq", 8'd0, 3);
    chk("R8 byte0", rbuf[0], 8'h30);
    chk("R8 byte1", rbuf[1], 8'h11);
    chk("R8 byte2", rbuf[2], 8'h3C);
  endtask

  task automatic t_badaddr();
    logic nk;
    bstart();
    send_byte(8'hA0, 1'b0, nk); chk("R1 foreign addr nack", nk, 1'b1);
    send_byte(8'h01, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    send_byte(8'h77, 1'b0, nk);
    bstop();
    chk("R1 div_a unchanged", div_a, 8'h11);
  endtask

  task automatic t_abort();
    logic nk;
    bstart();
    send_byte(8'hD4, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bstop();
    chk("R9 stop mid byte", div_a, 8'h11);
    bstart();
    send_byte(8'hD4, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    bstart();
    send_byte(8'hD4, 1'b0, nk); chk("R9 restart addr ack", nk, 1'b0);
    send_byte(8'h02, 1'b0, nk);
    send_byte(8'h01, 1'b0, nk);
    send_byte(8'h5A, 1'b0, nk); chk("R9 restart data ack", nk, 1'b0);
    bstop();
    chk("R9 start mid byte div_a", div_a, 8'h11);
    chk("R9 new write div_b", div_b, 8'h5A);
  endtask

  task automatic t_glitch();
    wbuf[0] = 8'hC3; wbuf[1] = 8'h96;
    do_write("glt", 8'd1, 2, 2, 1'b1);
    chk("R10 div_a with spikes", div_a, 8'hC3);
    chk("R10 div_b with spikes", div_b, 8'h96);
  endtask

  initial begin
    repeat (10) @(posedge clk);
    #1; rst = 1'b0;
    #99;
    t_reset();
    t_write();
    t_overrun();
    t_ctrl();
    t_reserved();
    t_read();
    t_badaddr();
    t_abort();
    t_glitch();
    chk("R11 drive changes with SCL high", drive_viol, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule